// File: doc/BRIEF.md
# Shared-Pool Ordered Mailbox Manager

This block keeps the message queues for a set of mailboxes used by tasks of a hardware scheduler. A message is a short descriptor: the number of the mailbox it belongs to, a small priority value and a 32-bit pointer to a payload that lives elsewhere. All mailboxes take their message slots from one common pool, so a busy mailbox can use slots that quiet mailboxes are not using. Each mailbox is set to one of three ordering modes. In arrival mode, messages and receivers are served in the order they came. In receiver-priority mode, a new message goes to the most urgent waiting task. In message-priority mode, the most urgent stored message is taken first.

A task sends, receives or polls with a single-cycle command and gets a status and a pointer back one cycle later. A receive on an empty mailbox registers the task as a waiter and can carry a timeout counted in `tick` strobes. A send to a mailbox that has a waiter hands the pointer straight to that task through the wake port and uses no slot. A timeout that expires also produces a wake, flagged as a timeout. The scheduler consumes the wake port. The block does not store or copy payloads.

Top module: `mbox_mgr`

## Requirements
- R1: After reset `rsp_valid` and `wake_valid` are 0, every mailbox is empty and in arrival mode, and the pool holds no message.
- R2: A command with `cmd_valid`=1 gives `rsp_valid`=1 exactly one cycle later, and no other cycle has `rsp_valid`=1. Opcodes: 0 send, 1 receive, 2 poll, 3 reserved. Status codes: 0 ok, 1 empty, 2 waiting, 3 pool full, 4 bad opcode.
- R3: In arrival mode (0) and receiver-priority mode (1), stored messages leave a mailbox in the order they were sent, whatever their priority.
- R4: In message-priority mode (2), a receive or poll returns the stored message with the lowest priority number. Messages with equal priority leave in the order they were sent.
- R5: A poll on an empty mailbox returns status 1 with pointer 0. It registers no waiter, so a later send to that mailbox is stored and produces no wake.
- R6: A receive on an empty mailbox returns status 2 with pointer 0 and registers `cmd_task` as a waiter, with `cmd_prio` as its task priority.
- R7: A send to a mailbox with an eligible waiter returns status 0 and uses no slot. One cycle later `wake_valid`=1, `wake_tmo`=0, and the wake carries the chosen task and the sent pointer. The earliest waiter is chosen in modes 0, 2 and 3. In mode 1 the waiter with the lowest priority number is chosen, and ties go to the earliest waiter.
- R8: A send that finds no waiter while all `N_SLOT` slots are in use returns status 3 and the message is dropped. Slots are shared, so a send to any mailbox is refused while the pool is full.
- R9: A waiter with a nonzero timeout T stops being eligible at the T-th `tick` after its receive. It is later released by a wake with `wake_tmo`=1 and pointer 0. A timeout of 0 never expires.
- R10: At most one wake is issued per cycle. A delivery wake goes before any pending timeout wake, and the timeout wakes follow in later cycles with no delivery.
- R11: Opcode 3 returns status 4 and changes no mailbox or waiter state.
- R12: `cfg_valid` writes `cfg_mode` into the mode of `cfg_mbox`. Mode value 3 behaves as arrival mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Mode write strobe |
| cfg_mbox | input | MB_W | Mailbox whose mode is written |
| cfg_mode | input | 2 | Ordering mode: 0 arrival, 1 receiver priority, 2 message priority |
| tick | input | 1 | Time-base strobe for receive timeouts |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode |
| cmd_mbox | input | MB_W | Target mailbox |
| cmd_task | input | TK_W | Calling task (used by receive) |
| cmd_prio | input | PRIO_W | Message priority (send) or task priority (receive) |
| cmd_ptr | input | PTR_W | Payload pointer (send) |
| cmd_tmo | input | TMO_W | Receive timeout in ticks, 0 means no limit |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 3 | Status code |
| rsp_ptr | output | PTR_W | Pointer returned by a receive or poll |
| wake_valid | output | 1 | Wake request to the scheduler |
| wake_task | output | TK_W | Task to wake |
| wake_ptr | output | PTR_W | Delivered pointer, 0 on timeout |
| wake_tmo | output | 1 | Wake caused by an expired timeout |

## Verification
The assertions take for granted that a task which is already waiting, or whose timeout has fired but whose wake has not yet appeared, does not issue another receive. They also assume that fewer than 2^31 ordered events separate any two live messages or waiters. The stimulus picks receiving tasks only from those the bench model shows as idle, and it stays far below the sequence-counter range. `tick` and commands are never driven in the same cycle, so every expiry falls cleanly between commands. Random traffic is concentrated on four mailboxes, one per mode value, so that waiters, stored messages and timeouts collide often.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int SEQ_W = 32;

  typedef enum logic [1:0] {
    OP_SEND = 2'd0,
    OP_RECV = 2'd1,
    OP_POLL = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_EMPTY = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FULL  = 3'd3,
    ST_BADOP = 3'd4
  } status_e;

  typedef enum logic [1:0] {
    ORD_FIFO    = 2'd0,
    ORD_TASKPRI = 2'd1,
    ORD_MSGPRI  = 2'd2,
    ORD_ALT     = 2'd3
  } order_e;

  // Wrap-safe age test: a was stamped before b.
  function automatic logic seq_older(input logic [SEQ_W-1:0] a,
                                     input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  // Ordering key: lower priority number first, then older stamp.
  function automatic logic key_first(input logic [7:0]       pa,
                                     input logic [SEQ_W-1:0] sa,
                                     input logic [7:0]       pb,
                                     input logic [SEQ_W-1:0] sb);
    if (pa != pb) return pa < pb;
    return seq_older(sa, sb);
  endfunction

endpackage

// File: rtl/mbox_slot_pool.sv
module mbox_slot_pool
  import mbox_pkg::*;
#(
  parameter int N_SLOT = 192,
  parameter int MB_W   = 6,
  parameter int PRIO_W = 4,
  parameter int PTR_W  = 32,
  localparam int IDX_W = $clog2(N_SLOT),
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MB_W-1:0]   sel_mbox,
  input  logic              sel_use_prio,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [PTR_W-1:0]  hit_ptr,
  output logic              has_free,
  input  logic              ins_en,
  input  logic [MB_W-1:0]   ins_mbox,
  input  logic [PRIO_W-1:0] ins_prio,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [PTR_W-1:0]  ins_ptr,
  input  logic              rm_en,
  output logic [CNT_W-1:0]  used
);

  logic [N_SLOT-1:0] vld;
  logic [MB_W-1:0]   s_mb  [N_SLOT];
  logic [PRIO_W-1:0] s_pr  [N_SLOT];
  logic [SEQ_W-1:0]  s_sq  [N_SLOT];
  logic [PTR_W-1:0]  s_pt  [N_SLOT];

  logic [IDX_W-1:0]  free_idx;
  logic [7:0]        best_p;
  logic [SEQ_W-1:0]  best_s;
  logic [7:0]        cand_p;

  // Best matching slot for the addressed mailbox.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    best_p  = '0;
    best_s  = '0;
    cand_p  = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      cand_p = sel_use_prio ? 8'(s_pr[i]) : 8'd0;
      if (vld[i] && s_mb[i] == sel_mbox) begin
        if (!hit || key_first(cand_p, s_sq[i], best_p, best_s)) begin
          hit     = 1'b1;
          hit_idx = IDX_W'(i);
          best_p  = cand_p;
          best_s  = s_sq[i];
        end
      end
    end
  end

  assign hit_ptr  = s_pt[hit_idx];
  assign has_free = (used != CNT_W'(N_SLOT));

  // Lowest free slot.
  always_comb begin
    free_idx = '0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      used <= '0;
    end else begin
      if (ins_en && has_free) vld[free_idx] <= 1'b1;
      if (rm_en && hit)       vld[hit_idx]  <= 1'b0;
      used <= used + CNT_W'(ins_en && has_free) - CNT_W'(rm_en && hit);
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && has_free) begin
      s_mb[free_idx] <= ins_mbox;
      s_pr[free_idx] <= ins_prio;
      s_sq[free_idx] <= ins_seq;
      s_pt[free_idx] <= ins_ptr;
    end
  end

endmodule

// File: rtl/mbox_wait_table.sv
module mbox_wait_table
  import mbox_pkg::*;
#(
  parameter int N_TASK = 64,
  parameter int MB_W   = 6,
  parameter int PRIO_W = 4,
  parameter int TMO_W  = 16,
  localparam int TK_W  = $clog2(N_TASK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MB_W-1:0]   sel_mbox,
  input  logic              sel_use_prio,
  output logic              hit,
  output logic [TK_W-1:0]   hit_task,
  input  logic              add_en,
  input  logic [TK_W-1:0]   add_task,
  input  logic [MB_W-1:0]   add_mbox,
  input  logic [PRIO_W-1:0] add_prio,
  input  logic [SEQ_W-1:0]  add_seq,
  input  logic [TMO_W-1:0]  add_tmo,
  input  logic              del_en,
  input  logic              port_busy,
  output logic              exp_fire,
  output logic [TK_W-1:0]   exp_task
);

  logic [N_TASK-1:0] w_on;
  logic [N_TASK-1:0] w_exp;
  logic [MB_W-1:0]   w_mb  [N_TASK];
  logic [PRIO_W-1:0] w_pr  [N_TASK];
  logic [SEQ_W-1:0]  w_sq  [N_TASK];
  logic [TMO_W-1:0]  w_cnt [N_TASK];

  logic [7:0]        best_p;
  logic [SEQ_W-1:0]  best_s;
  logic [7:0]        cand_p;
  logic              exp_any;

  // Eligible waiter for the addressed mailbox.
  always_comb begin
    hit      = 1'b0;
    hit_task = '0;
    best_p   = '0;
    best_s   = '0;
    cand_p   = '0;
    for (int i = 0; i < N_TASK; i++) begin
      cand_p = sel_use_prio ? 8'(w_pr[i]) : 8'd0;
      if (w_on[i] && !w_exp[i] && w_mb[i] == sel_mbox) begin
        if (!hit || key_first(cand_p, w_sq[i], best_p, best_s)) begin
          hit      = 1'b1;
          hit_task = TK_W'(i);
          best_p   = cand_p;
          best_s   = w_sq[i];
        end
      end
    end
  end

  // Lowest expired waiter still owed a timeout wake.
  always_comb begin
    exp_any  = 1'b0;
    exp_task = '0;
    for (int i = N_TASK - 1; i >= 0; i--) begin
      if (w_on[i] && w_exp[i]) begin
        exp_any  = 1'b1;
        exp_task = TK_W'(i);
      end
    end
  end

  assign exp_fire = exp_any && !port_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_on  <= '0;
      w_exp <= '0;
    end else begin
      for (int i = 0; i < N_TASK; i++) begin
        if (del_en && hit_task == TK_W'(i)) begin
          w_on[i]  <= 1'b0;
          w_exp[i] <= 1'b0;
        end else if (exp_fire && exp_task == TK_W'(i)) begin
          w_on[i]  <= 1'b0;
          w_exp[i] <= 1'b0;
        end else if (add_en && add_task == TK_W'(i)) begin
          w_on[i]  <= 1'b1;
          w_exp[i] <= 1'b0;
        end else if (tick && w_on[i] && !w_exp[i] && w_cnt[i] != '0) begin
          if (w_cnt[i] == TMO_W'(1)) w_exp[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_TASK; i++) begin
      if (add_en && add_task == TK_W'(i)) begin
        w_mb[i]  <= add_mbox;
        w_pr[i]  <= add_prio;
        w_sq[i]  <= add_seq;
        w_cnt[i] <= add_tmo;
      end else if (tick && w_on[i] && !w_exp[i] && w_cnt[i] != '0) begin
        w_cnt[i] <= w_cnt[i] - TMO_W'(1);
      end
    end
  end

endmodule

// File: rtl/mbox_mgr.sv
module mbox_mgr
  import mbox_pkg::*;
#(
  parameter int N_MBOX = 64,
  parameter int N_SLOT = 192,
  parameter int N_TASK = 64,
  parameter int PRIO_W = 4,
  parameter int PTR_W  = 32,
  parameter int TMO_W  = 16,
  localparam int MB_W  = $clog2(N_MBOX),
  localparam int TK_W  = $clog2(N_TASK),
  localparam int IDX_W = $clog2(N_SLOT),
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [MB_W-1:0]   cfg_mbox,
  input  logic [1:0]        cfg_mode,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [MB_W-1:0]   cmd_mbox,
  input  logic [TK_W-1:0]   cmd_task,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [TMO_W-1:0]  cmd_tmo,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [PTR_W-1:0]  rsp_ptr,
  output logic              wake_valid,
  output logic [TK_W-1:0]   wake_task,
  output logic [PTR_W-1:0]  wake_ptr,
  output logic              wake_tmo
);

  logic [1:0]       mode_q [N_MBOX];
  logic [1:0]       cur_mode;
  logic [SEQ_W-1:0] seq_q;

  // Named internal events, also used by the checker.
  logic is_send, is_recv, is_poll, is_bad;
  logic deliver, enqueue, full_rej, take, block, poll_empty;

  logic             s_hit, s_free;
  logic [IDX_W-1:0] s_idx;
  logic [PTR_W-1:0] s_ptr;
  logic [CNT_W-1:0] used_cnt;
  logic             w_hit;
  logic [TK_W-1:0]  w_task;
  logic             exp_fire;
  logic [TK_W-1:0]  exp_task;

  status_e          nxt_status;
  logic [PTR_W-1:0] nxt_ptr;

  assign cur_mode = mode_q[cmd_mbox];

  assign is_send = cmd_valid && cmd_op == OP_SEND;
  assign is_recv = cmd_valid && cmd_op == OP_RECV;
  assign is_poll = cmd_valid && cmd_op == OP_POLL;
  assign is_bad  = cmd_valid && cmd_op == OP_RSVD;

  assign deliver    = is_send && w_hit;
  assign enqueue    = is_send && !w_hit && s_free;
  assign full_rej   = is_send && !w_hit && !s_free;
  assign take       = (is_recv || is_poll) && s_hit;
  assign block      = is_recv && !s_hit;
  assign poll_empty = is_poll && !s_hit;

  mbox_slot_pool #(
    .N_SLOT(N_SLOT), .MB_W(MB_W), .PRIO_W(PRIO_W), .PTR_W(PTR_W)
  ) i_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_mbox    (cmd_mbox),
    .sel_use_prio(cur_mode == ORD_MSGPRI),
    .hit         (s_hit),
    .hit_idx     (s_idx),
    .hit_ptr     (s_ptr),
    .has_free    (s_free),
    .ins_en      (enqueue),
    .ins_mbox    (cmd_mbox),
    .ins_prio    (cmd_prio),
    .ins_seq     (seq_q),
    .ins_ptr     (cmd_ptr),
    .rm_en       (take),
    .used        (used_cnt)
  );

  mbox_wait_table #(
    .N_TASK(N_TASK), .MB_W(MB_W), .PRIO_W(PRIO_W), .TMO_W(TMO_W)
  ) i_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sel_mbox    (cmd_mbox),
    .sel_use_prio(cur_mode == ORD_TASKPRI),
    .hit         (w_hit),
    .hit_task    (w_task),
    .add_en      (block),
    .add_task    (cmd_task),
    .add_mbox    (cmd_mbox),
    .add_prio    (cmd_prio),
    .add_seq     (seq_q),
    .add_tmo     (cmd_tmo),
    .del_en      (deliver),
    .port_busy   (deliver),
    .exp_fire    (exp_fire),
    .exp_task    (exp_task)
  );

  always_comb begin
    nxt_status = ST_OK;
    nxt_ptr    = '0;
    if (is_bad)               nxt_status = ST_BADOP;
    else if (full_rej)        nxt_status = ST_FULL;
    else if (take)            nxt_ptr    = s_ptr;
    else if (block)           nxt_status = ST_WAIT;
    else if (poll_empty)      nxt_status = ST_EMPTY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < N_MBOX; m++) mode_q[m] <= ORD_FIFO;
    end else if (cfg_valid) begin
      mode_q[cfg_mbox] <= cfg_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_ptr    <= '0;
      wake_valid <= 1'b0;
      wake_task  <= '0;
      wake_ptr   <= '0;
      wake_tmo   <= 1'b0;
    end else begin
      if (enqueue || block) seq_q <= seq_q + SEQ_W'(1);
      rsp_valid  <= cmd_valid;
      rsp_status <= nxt_status;
      rsp_ptr    <= nxt_ptr;
      wake_valid <= deliver || exp_fire;
      wake_task  <= deliver ? w_task : exp_task;
      wake_ptr   <= deliver ? cmd_ptr : '0;
      wake_tmo   <= !deliver && exp_fire;
    end
  end

endmodule

// File: rtl/mbox_mgr_chk.sv
module mbox_mgr_chk
  import mbox_pkg::*;
#(
  parameter int N_SLOT = 192,
  parameter int PTR_W  = 32,
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             rsp_valid,
  input logic [2:0]       rsp_status,
  input logic [PTR_W-1:0] rsp_ptr,
  input logic             wake_valid,
  input logic             wake_tmo,
  input logic             deliver,
  input logic             enqueue,
  input logic             full_rej,
  input logic             poll_empty,
  input logic             block,
  input logic [CNT_W-1:0] used_cnt
);

  // R2
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  // R7
  deliver_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> wake_valid && !wake_tmo && rsp_status == ST_OK);

  // R7
  deliver_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> $stable(used_cnt));

  // R8
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_rej |=> rsp_status == ST_FULL && used_cnt == CNT_W'(N_SLOT));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= CNT_W'(N_SLOT));

  // R8
  enqueue_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enqueue |=> used_cnt == $past(used_cnt) + CNT_W'(1));

  // R5
  poll_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_empty |=> rsp_status == ST_EMPTY && rsp_ptr == '0 && $stable(used_cnt));

  // R6
  recv_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> rsp_status == ST_WAIT && rsp_ptr == '0);

endmodule

bind mbox_mgr mbox_mgr_chk #(.N_SLOT(N_SLOT), .PTR_W(PTR_W)) i_mbox_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .rsp_valid (rsp_valid),
  .rsp_status(rsp_status),
  .rsp_ptr   (rsp_ptr),
  .wake_valid(wake_valid),
  .wake_tmo  (wake_tmo),
  .deliver   (deliver),
  .enqueue   (enqueue),
  .full_rej  (full_rej),
  .poll_empty(poll_empty),
  .block     (block),
  .used_cnt  (used_cnt)
);

// File: tb/test_mbox_mgr.sv
module test_mbox_mgr;

  localparam int NMB = 64, NSL = 192, NTK = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [5:0]  cfg_mbox = '0;
  logic [1:0]  cfg_mode = '0;
  logic        tick = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [5:0]  cmd_mbox = '0;
  logic [5:0]  cmd_task = '0;
  logic [3:0]  cmd_prio = '0;
  logic [31:0] cmd_ptr = '0;
  logic [15:0] cmd_tmo = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_ptr;
  logic        wake_valid;
  logic [5:0]  wake_task;
  logic [31:0] wake_ptr;
  logic        wake_tmo;

  always #10 clk = ~clk;

  mbox_mgr i_mbox_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_mbox(cfg_mbox),
    .cfg_mode(cfg_mode), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mbox(cmd_mbox), .cmd_task(cmd_task), .cmd_prio(cmd_prio),
    .cmd_ptr(cmd_ptr), .cmd_tmo(cmd_tmo), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_ptr(rsp_ptr), .wake_valid(wake_valid),
    .wake_task(wake_task), .wake_ptr(wake_ptr), .wake_tmo(wake_tmo)
  );

  // Reference model
  typedef struct { logic [31:0] ptr; int prio; } msg_t;
  msg_t q [NMB][$];
  int   pool_n = 0;
  int   mode_m [NMB];
  bit   w_on [NTK];
  bit   w_exp [NTK];
  int   w_mb [NTK];
  int   w_pr [NTK];
  int   w_ord [NTK];
  int   w_cnt [NTK];
  int   ord_n = 0;
  int   tmo_seen = 0;

  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int pick_waiter(input int mb);
    int best = -1;
    for (int t = 0; t < NTK; t++) begin
      if (w_on[t] && !w_exp[t] && w_mb[t] == mb) begin
        if (best < 0) best = t;
        else if (mode_m[mb] == 1 &&
                 (w_pr[t] < w_pr[best] || (w_pr[t] == w_pr[best] && w_ord[t] < w_ord[best])))
          best = t;
        else if (mode_m[mb] != 1 && w_ord[t] < w_ord[best]) best = t;
      end
    end
    return best;
  endfunction

  function automatic int pick_msg(input int mb);
    int best = 0;
    if (mode_m[mb] != 2) return 0;
    for (int k = 1; k < q[mb].size(); k++)
      if (q[mb][k].prio < q[mb][best].prio) best = k;
    return best;
  endfunction

  // One cycle: drive at negedge, check at next negedge.
  task automatic step(input bit v, input int op, input int mb, input int tk,
                      input int pr, input logic [31:0] ptr, input int tmo,
                      input bit tk_strobe, input string tag);
    int  e_st = 0;
    logic [31:0] e_ptr = '0;
    bit  e_dlv = 0;
    int  e_wt = 0;
    if (v) begin
      if (op == 0) begin
        int w = pick_waiter(mb);
        if (w >= 0) begin
          e_dlv = 1; e_wt = w; w_on[w] = 0;
        end else if (pool_n < NSL) begin
          msg_t m; m.ptr = ptr; m.prio = pr; q[mb].push_back(m); pool_n++;
        end else e_st = 3;
      end else if (op == 1 || op == 2) begin
        if (q[mb].size() > 0) begin
          int k = pick_msg(mb);
          e_ptr = q[mb][k].ptr; q[mb].delete(k); pool_n--;
        end else if (op == 2) e_st = 1;
        else begin
          e_st = 2; w_on[tk] = 1; w_exp[tk] = 0; w_mb[tk] = mb; w_pr[tk] = pr;
          w_ord[tk] = ord_n++; w_cnt[tk] = tmo;
        end
      end else e_st = 4;
    end
    if (tk_strobe) begin
      for (int t = 0; t < NTK; t++)
        if (w_on[t] && !w_exp[t] && w_cnt[t] != 0) begin
          w_cnt[t]--;
          if (w_cnt[t] == 0) w_exp[t] = 1;
        end
    end
    cmd_valid = v; cmd_op = 2'(op); cmd_mbox = 6'(mb); cmd_task = 6'(tk);
    cmd_prio = 4'(pr); cmd_ptr = ptr; cmd_tmo = 16'(tmo); tick = tk_strobe;
    @(negedge clk);
    cmd_valid = 0; tick = 0;
    if (v) begin
      chk(rsp_valid == 1, tag, "rsp_valid", rsp_valid, 1);
      chk(rsp_status == 3'(e_st), tag, "status", rsp_status, e_st);
      chk(rsp_ptr == e_ptr, tag, "ptr", rsp_ptr, e_ptr);
    end else chk(rsp_valid == 0, "R2", "idle rsp_valid", rsp_valid, 0);
    if (e_dlv) begin
      chk(wake_valid && !wake_tmo, "R7", "delivery wake", {wake_valid, wake_tmo}, 2);
      chk(wake_task == 6'(e_wt), "R7", "wake task", wake_task, e_wt);
      chk(wake_ptr == ptr, "R7", "wake ptr", wake_ptr, ptr);
    end else if (wake_valid) begin
      chk(wake_tmo == 1, "R10", "unexpected delivery wake", wake_task, 0);
      chk(w_on[wake_task] && w_exp[wake_task], "R9", "timeout wake task",
          wake_task, wake_task);
      chk(wake_ptr == 0, "R9", "timeout wake ptr", wake_ptr, 0);
      w_on[wake_task] = 0; w_exp[wake_task] = 0; tmo_seen++;
    end
  endtask

  task automatic cfg(input int mb, input int md);
    cfg_valid = 1; cfg_mbox = 6'(mb); cfg_mode = 2'(md);
    @(negedge clk);
    cfg_valid = 0;
    mode_m[mb] = (md == 3) ? 0 : md;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int t0;
    void'($urandom(32'h5EED_0042));
    for (int m = 0; m < NMB; m++) mode_m[m] = 0;
    for (int t = 0; t < NTK; t++) begin w_on[t] = 0; w_exp[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 0 && wake_valid == 0, "R1", "reset outputs",
        {rsp_valid, wake_valid}, 0);
    step(1, 2, 0, 0, 0, 0, 0, 0, "R1");
    // R12 modes; mode 3 acts as arrival order
    cfg(1, 1); cfg(2, 2); cfg(3, 3);
    // R3 arrival order ignores message priority
    step(1, 0, 0, 0, 3, 32'hA0, 0, 0, "R3");
    step(1, 0, 0, 0, 1, 32'hA1, 0, 0, "R3");
    step(1, 0, 0, 0, 2, 32'hA2, 0, 0, "R3");
    for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 0, 3, 32'hB0, 0, 0, "R3");
    step(1, 0, 1, 0, 0, 32'hB1, 0, 0, "R3");
    for (int k = 0; k < 2; k++) step(1, 2, 1, 0, 0, 0, 0, 0, "R3");
    // R4 message priority with equal-priority ties
    step(1, 0, 2, 0, 3, 32'hC0, 0, 0, "R4");
    step(1, 0, 2, 0, 1, 32'hC1, 0, 0, "R4");
    step(1, 0, 2, 0, 3, 32'hC2, 0, 0, "R4");
    step(1, 0, 2, 0, 0, 32'hC3, 0, 0, "R4");
    step(1, 0, 2, 0, 1, 32'hC4, 0, 0, "R4");
    for (int k = 0; k < 5; k++) step(1, 1, 2, 0, 0, 0, 0, 0, "R4");
    // R12 mode 3 behaves as arrival order
    step(1, 0, 3, 0, 2, 32'hD0, 0, 0, "R12");
    step(1, 0, 3, 0, 0, 32'hD1, 0, 0, "R12");
    for (int k = 0; k < 2; k++) step(1, 2, 3, 0, 0, 0, 0, 0, "R12");
    // R6 / R7 waiters in arrival and receiver-priority modes
    step(1, 1, 0, 1, 0, 0, 0, 0, "R6");
    step(1, 1, 0, 2, 0, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 32'hE0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 32'hE1, 0, 0, "R7");
    step(1, 1, 1, 3, 5, 0, 0, 0, "R6");
    step(1, 1, 1, 4, 2, 0, 0, 0, "R6");
    step(1, 1, 1, 5, 2, 0, 0, 0, "R6");
    for (int k = 0; k < 3; k++) step(1, 0, 1, 0, 0, 32'hF0 + k, 0, 0, "R7");
    step(1, 1, 2, 6, 9, 0, 0, 0, "R6");
    step(1, 1, 2, 7, 0, 0, 0, 0, "R6");
    step(1, 0, 2, 0, 0, 32'hF8, 0, 0, "R7");
    step(1, 0, 2, 0, 0, 32'hF9, 0, 0, "R7");
    // R5 poll registers nothing
    step(1, 2, 0, 8, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 32'h51, 0, 0, "R5");
    step(1, 2, 0, 0, 0, 0, 0, 0, "R5");
    // R11 reserved opcode
    step(1, 0, 0, 0, 0, 32'h61, 0, 0, "R11");
    step(1, 3, 0, 9, 0, 32'h62, 0, 0, "R11");
    step(1, 2, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 2, 0, 0, 0, 0, 0, 0, "R11");
    // R9 timeout after three ticks, and an unlimited waiter
    step(1, 1, 5, 9, 0, 0, 3, 0, "R9");
    step(1, 1, 5, 10, 0, 0, 0, 0, "R9");
    t0 = tmo_seen;
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    chk(tmo_seen == t0 + 1, "R9", "timeout wakes", tmo_seen, t0 + 1);
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(1, 0, 5, 0, 0, 32'h90, 0, 0, "R9");
    // R10 delivery preempts a pending timeout wake; expired waiter skipped
    step(1, 1, 6, 11, 0, 0, 1, 0, "R10");
    step(1, 1, 6, 12, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R10");
    step(1, 0, 6, 0, 0, 32'hAA, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    chk(!w_on[11], "R10", "timeout wake after delivery", w_on[11], 0);
    // R8 fill the shared pool across mailboxes
    for (int k = 0; k < NSL; k++)
      step(1, 0, 10 + (k % 6), 0, k % 4, 32'h1000 + k, 0, 0, "R8");
    step(1, 0, 20, 0, 0, 32'h2000, 0, 0, "R8");
    step(1, 0, 10, 0, 0, 32'h2001, 0, 0, "R8");
    step(1, 2, 20, 0, 0, 0, 0, 0, "R8");
    for (int k = 0; k < NSL; k++) step(1, 2, 10 + (k % 6), 0, 0, 0, 0, 0, "R8");
    // Random mix on mailboxes 0..3
    for (int n = 0; n < 900; n++) begin
      int r = $urandom_range(0, 99);
      int mb = $urandom_range(0, 3);
      if (r < 15) step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
      else if (r < 50) step(1, 0, mb, 0, $urandom_range(0, 3), $urandom(), 0, 0, "R7");
      else if (r < 65) step(1, 2, mb, 0, 0, 0, 0, 0, "R5");
      else if (r < 98) begin
        int tk = $urandom_range(16, 23);
        if (!w_on[tk])
          step(1, 1, mb, tk, $urandom_range(0, 3), 0,
               ($urandom_range(0, 1) == 1) ? $urandom_range(1, 6) : 0, 0, "R6");
        else step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
      end else step(1, 3, mb, 0, 0, 32'h77, 0, 0, "R11");
    end
    // drain pending timeout wakes
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    begin
      int left = 0;
      for (int t = 0; t < NTK; t++) if (w_on[t] && w_exp[t]) left++;
      chk(left == 0, "R10", "undelivered timeout wakes", left, 0);
    end
    finish_run();
  end

endmodule